// File: doc/BRIEF.md
# Tree Pseudo-LRU Replacement State

This block keeps the replacement history for a set-associative cache with a power-of-two number of ways. Each set owns a small binary tree of N-1 bits arranged in heap order: node i has its left child at 2i+1 and its right child at 2i+2, and the nodes that decide between pairs of ways begin at index (N-1)/2. Bit value 0 selects the left child and 1 selects the right child. The tree does not remember the full access order. It approximates least-recently-used replacement with one bit per internal node.

A cache controller uses two independent ports. A touch port, qualified by a valid strobe, records that a way of a set was just used. The block rewrites the path from that way's leaf node to the root so that every bit on the path points away from the used way. A victim port takes a set index and returns, in the same cycle, the way reached by walking from the root. A clear strobe zeroes every tree of every set, so a fresh set hands out way 0 first. Tag comparison and data storage belong to the surrounding cache.

Top module: `plru_tree_repl`

## Requirements
- R1: After reset every tree bit of every set is 0, so the victim for every set is way 0.
- R2: The victim is found from the root (node 0) by going to node 2i+1 when bit i is 0 and to node 2i+2 when it is 1, until a node with index at least (N-1)/2 is reached. The way is then 2*(node-(N-1)/2) plus that node's bit.
- R3: On a touch of way w, leaf node w/2+(N-1)/2 is written to 1 when w is even and to 0 when w is odd.
- R4: After the leaf, every ancestor on the path to the root is written with (child index mod 2): 1 when the path comes up from a left (odd) child and 0 when it comes from a right (even) child. Nodes off the path keep their values.
- R5: With N greater than 1, the victim of a set in the cycle after a touch of way w of that set is never w.
- R6: victim_way depends combinationally on victim_set and the stored bits, and reflects a new victim_set in the same cycle.
- R7: A touch changes the tree only on a rising clock edge with touch_valid high, and only for the set given by touch_set. Other sets keep their victims.
- R8: clear_all high at a clock edge zeroes every bit of every set, so every set then gives victim way 0.
- R9: When clear_all and touch_valid are both high at the same edge, the clear wins and the touch is dropped.
- R10: With N = 1 the victim is always way 0, and touches change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_all | input | 1 | Zero the trees of all sets at the next edge |
| touch_valid | input | 1 | Record an access at the next edge |
| touch_set | input | SET_W | Set index of the access |
| touch_way | input | WAY_W | Way that was accessed |
| victim_set | input | SET_W | Set index to query for replacement |
| victim_way | output | WAY_W | Way to replace in victim_set |

## Verification
On every cycle the assertions check that a clear yields victim 0 on the next cycle, that a touch moves the victim of the touched set away from the touched way, that the victim of a set stays put when neither a clear nor a touch of that set occurred, and that a one-way build always answers way 0. The exact leaf and ancestor encodings, the full root-to-leaf walk, and the priority of clear over a simultaneous touch show only through the bench. The bench drives known touch sequences with hand-derived victims, and random traffic that it compares each clock against a heap-indexed reference tree.

// File: rtl/plru_pkg.sv
package plru_pkg;
  localparam int unsigned MAX_NODES = 7;   // up to 8 ways
  typedef logic [MAX_NODES-1:0] tree_t;

  // Rewrite the path of a touched way so it points away from it.
  function automatic tree_t tree_touch(tree_t t, logic [2:0] way, int unsigned ways);
    tree_t r;
    logic [2:0] node;
    logic [2:0] bottom;
    r = t;
    if (ways < 2) return t;
    bottom = 3'((ways - 1) / 2);
    node = (way >> 1) + bottom;
    r[node] = ~way[0];
    for (int lvl = 0; lvl < 3; lvl++) begin
      if (node != 3'd0) begin
        r[(node - 3'd1) >> 1] = node[0];
        node = (node - 3'd1) >> 1;
      end
    end
    return r;
  endfunction

  // Walk from the root to a bottom node and form the way number.
  function automatic logic [2:0] tree_pick(tree_t t, int unsigned ways);
    logic [2:0] node;
    logic [2:0] bottom;
    if (ways < 2) return 3'd0;
    bottom = 3'((ways - 1) / 2);
    node = 3'd0;
    for (int lvl = 0; lvl < 3; lvl++) begin
      if (node < bottom)
        node = t[node] ? ((node << 1) + 3'd2) : ((node << 1) + 3'd1);
    end
    return ((node - bottom) << 1) | {2'b00, t[node]};
  endfunction
endpackage

// File: rtl/plru_tree_store.sv
module plru_tree_store
  import plru_pkg::*;
#(
  parameter int unsigned WAYS  = 8,
  parameter int unsigned SETS  = 4,
  localparam int unsigned NODES = (WAYS > 1) ? WAYS - 1 : 1,
  localparam int unsigned SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [SET_W-1:0] rd_set,
  output tree_t            rd_tree
);
  tree_t all_q [SETS];

  for (genvar g = 0; g < SETS; g++) begin : g_set
    logic [NODES-1:0] q;
    tree_t cur;
    tree_t nxt;
    assign cur = tree_t'(q);
    assign nxt = tree_touch(cur, 3'(wr_way), WAYS);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                q <= '0;
      else if (clr)                              q <= '0;
      else if (wr_en && wr_set == SET_W'(g))     q <= nxt[NODES-1:0];
    end
    assign all_q[g] = cur;
  end

  assign rd_tree = all_q[rd_set];
endmodule

// File: rtl/plru_tree_walk.sv
module plru_tree_walk
  import plru_pkg::*;
#(
  parameter int unsigned WAYS = 8,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  tree_t            tree,
  output logic [WAY_W-1:0] way
);
  logic [2:0] pick;
  assign pick = tree_pick(tree, WAYS);
  assign way  = pick[WAY_W-1:0];
endmodule

// File: rtl/plru_tree_repl.sv
module plru_tree_repl
  import plru_pkg::*;
#(
  parameter int unsigned WAYS = 8,
  parameter int unsigned SETS = 4,
  localparam int unsigned SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_all,
  input  logic             touch_valid,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [SET_W-1:0] victim_set,
  output logic [WAY_W-1:0] victim_way
);
  // Named events for the checker.
  logic  touch_fire;
  tree_t vic_tree;

  assign touch_fire = touch_valid & ~clear_all;   // R9: clear wins

  plru_tree_store #(.WAYS(WAYS), .SETS(SETS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clear_all),
    .wr_en   (touch_fire),
    .wr_set  (touch_set),
    .wr_way  (touch_way),
    .rd_set  (victim_set),
    .rd_tree (vic_tree)
  );

  plru_tree_walk #(.WAYS(WAYS)) u_walk (
    .tree (vic_tree),
    .way  (victim_way)
  );
endmodule

// File: rtl/plru_tree_chk.sv
module plru_tree_chk #(
  parameter int unsigned WAYS = 8,
  parameter int unsigned SETS = 4,
  localparam int unsigned SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear_all,
  input logic             touch_fire,
  input logic [SET_W-1:0] touch_set,
  input logic [WAY_W-1:0] touch_way,
  input logic [SET_W-1:0] victim_set,
  input logic [WAY_W-1:0] victim_way
);
  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> (victim_way == '0));

  assert_set_isolation_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_all && !(touch_fire && touch_set == victim_set))
      |=> ($stable(victim_set) -> $stable(victim_way)));

  if (WAYS > 1) begin : g_multi
    assert_move_away_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (touch_fire && touch_set == victim_set)
        |=> (victim_set != $past(victim_set)) || (victim_way != $past(touch_way)));
  end else begin : g_single
    assert_single_way_R10: assert property (@(posedge clk) disable iff (!rst_n)
      victim_way == '0);
  end
endmodule

bind plru_tree_repl plru_tree_chk #(.WAYS(WAYS), .SETS(SETS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clear_all  (clear_all),
  .touch_fire (touch_fire),
  .touch_set  (touch_set),
  .touch_way  (touch_way),
  .victim_set (victim_set),
  .victim_way (victim_way)
);

// File: tb/plru_tree_repl_tb.sv
module plru_tree_repl_tb;
  localparam int WAYS = 8;
  localparam int SETS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear_all = 1'b0;
  logic       touch_valid = 1'b0;
  logic [1:0] touch_set = '0;
  logic [2:0] touch_way = '0;
  logic [1:0] victim_set = '0;
  logic [2:0] victim_way;
  logic       vic_one;

  int n_checks = 0;
  int n_fail = 0;
  int tr [SETS][8];

  always #2.5 clk = ~clk;   // 200 MHz

  plru_tree_repl #(.WAYS(WAYS), .SETS(SETS)) u_dut (
    .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .touch_valid(touch_valid),
    .touch_set(touch_set), .touch_way(touch_way), .victim_set(victim_set),
    .victim_way(victim_way));

  plru_tree_repl #(.WAYS(1), .SETS(SETS)) u_dut_one (
    .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .touch_valid(touch_valid),
    .touch_set(touch_set), .touch_way(touch_way[0]), .victim_set(victim_set),
    .victim_way(vic_one));

  // Reference tree: heap indices, leaves from (WAYS-1)/2.
  function automatic void ref_clear();
    for (int s = 0; s < SETS; s++) for (int k = 0; k < 8; k++) tr[s][k] = 0;
  endfunction

  function automatic void ref_touch(int s, int w);
    int node;
    node = w / 2 + (WAYS - 1) / 2;
    tr[s][node] = (w % 2 == 0) ? 1 : 0;
    while (node > 0) begin
      tr[s][(node - 1) / 2] = node % 2;
      node = (node - 1) / 2;
    end
  endfunction

  function automatic int ref_pick(int s);
    int node;
    node = 0;
    while (node < (WAYS - 1) / 2) node = (tr[s][node] == 0) ? 2 * node + 1 : 2 * node + 2;
    return 2 * (node - (WAYS - 1) / 2) + tr[s][node];
  endfunction

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive one cycle; victim checked before the edge, model applied after it.
  task automatic cycle(bit clr, bit upd, int us, int uw, int vs, string tag);
    @(negedge clk);
    clear_all = clr; touch_valid = upd;
    touch_set = 2'(us); touch_way = 3'(uw); victim_set = 2'(vs);
    #1;
    check(tag, int'(victim_way), ref_pick(vs));
    check("R10 one-way victim", int'(vic_one), 0);
    @(posedge clk);
    if (clr) ref_clear();
    else if (upd) ref_touch(us, uw);
  endtask

  task automatic probe(int vs, int exp, string tag);
    @(negedge clk);
    clear_all = 0; touch_valid = 0; victim_set = 2'(vs);
    #1;
    check(tag, int'(victim_way), exp);
    check(tag, int'(victim_way), ref_pick(vs));
    @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    ref_clear();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: reset state
    for (int s = 0; s < SETS; s++) probe(s, 0, "R1 reset victim");

    // R3 R4 R2: touch way 0 -> victim 4, then touch 4 -> victim 2
    cycle(0, 1, 1, 0, 1, "R6 pre-touch");
    probe(1, 4, "R3 R4 R2 after touching way 0");
    cycle(0, 1, 1, 4, 1, "R6 pre-touch");
    probe(1, 2, "R3 R4 R2 after touching way 4");
    // odd way: touch 7 -> leaf 6 gets 0; victim walk
    cycle(0, 1, 2, 7, 2, "R6 pre-touch");
    probe(2, 0, "R3 odd way leaf");
    // R7: other sets unaffected, no change without valid
    probe(0, 0, "R7 untouched set");
    cycle(0, 0, 0, 3, 0, "R7 valid low");
    probe(0, 0, "R7 touch ignored without valid");
    // R5: touch each way of set 3, victim differs
    for (int w = 0; w < WAYS; w++) begin
      cycle(0, 1, 3, w, 3, "R6 sweep");
      @(negedge clk); victim_set = 2'd3; touch_valid = 0; #1;
      n_checks++;
      if (int'(victim_way) == w) begin
        n_fail++;
        $display("FAIL R5: actual %0d expected not %0d", victim_way, w);
      end
      @(posedge clk);
    end
    // R9: clear and touch together
    cycle(1, 1, 1, 0, 1, "R9 pre");
    probe(1, 0, "R9 clear beats touch");
    // R8: build state, then clear
    cycle(0, 1, 0, 1, 0, "R8 fill");
    cycle(0, 1, 2, 2, 2, "R8 fill");
    cycle(1, 0, 0, 0, 0, "R8 pre");
    for (int s = 0; s < SETS; s++) probe(s, 0, "R8 cleared victim");
    // random traffic, victim port moves every cycle (R6)
    for (int i = 0; i < 600; i++) begin
      cycle(($urandom % 40) == 0, ($urandom % 3) != 0, $urandom % SETS,
            $urandom % WAYS, $urandom % SETS, "R6 R2 random compare");
    end
    @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule